// File: doc/BRIEF.md
# Masked Exclusive Prefix Popcount Unit

This block turns a bit vector into a vector of running counts. For each lane i, the result is the number of set source bits at positions strictly below i. Only lanes that the predicate enables take part. A lane that the predicate disables adds nothing to the counts of higher lanes. It also keeps the previous destination value supplied for it, so a partial update merges into an existing result vector.

If the predicate is not in use, every lane is enabled. A select input can force the source to all ones. With that select and no predicate, the result is the lane index sequence 0, 1, ..., LANES-1. With that select and a predicate, each enabled lane gets the number of enabled lanes below it.

The result passes through one output register with a valid/ready handshake. One operand set can be accepted in every cycle in which the consumer takes the previous result.

Top module: `prefix_popcount_unit`

## Requirements
- R1: With mask_en low and src_ones low, dst lane i (bits [i*CNT_W +: CNT_W]) equals the number of ones in src bits 0 to i-1; for src 8'b10010001 the lanes 7..0 read 2,2,2,1,1,1,1,0.
- R2: With mask_en low, the mask input has no effect and every lane is enabled.
- R3: With mask_en high, a src bit whose mask bit is 0 is not counted by any higher lane; for mask 8'b11101011 and src 8'b10010001 the enabled lanes 7,6,5,3,1,0 read 1,1,1,1,1,0.
- R4: With mask_en high, a lane whose mask bit is 0 outputs its old_dst lane unchanged (for the R3 case with old lanes 7..0 = 2,3,4,5,6,7,8,9, lanes 4 and 2 read 5 and 7).
- R5: With src_ones high and mask_en low, dst lane i equals i.
- R6: An enabled lane 0 always reads 0.
- R7: An operand set is accepted on a rising clock edge where in_valid and in_ready are both high. Its result is on dst with out_valid high after that edge. in_ready is high whenever out_valid is low or out_ready is high.
- R8: While out_valid is high and out_ready is low, out_valid stays high and dst does not change.
- R9: Synchronous reset clears out_valid.
- R10: With src_ones high and mask_en high, each enabled lane reads the number of enabled lanes below it, and disabled lanes keep old_dst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand set present |
| in_ready | output | 1 | Operand set can be taken this cycle |
| src | input | LANES | Source bit vector, bit i belongs to lane i |
| mask_en | input | 1 | Use mask as lane predicate; low means all lanes enabled |
| mask | input | LANES | Lane predicate, 1 enables the lane |
| src_ones | input | 1 | Treat the source as all ones |
| old_dst | input | LANES*CNT_W | Previous lane values kept by disabled lanes |
| out_valid | output | 1 | dst holds a result |
| out_ready | input | 1 | Consumer takes the result |
| dst | output | LANES*CNT_W | Result lanes, lane i at bits [i*CNT_W +: CNT_W] |

## Verification
Every count and merge result is computed combinationally from the accepted operands. It is held in the single output register, so it is due exactly one rising edge after the edge that accepts it. in_ready responds to out_valid and out_ready within the same cycle. The bench drives on falling edges and reads dst, out_valid and in_ready on the next falling edge, half a period after the edge that changed them. Under backpressure it samples on several successive falling edges to see that the held result neither moves nor is replaced.

// File: rtl/ppc_pkg.sv
package ppc_pkg;

  localparam int unsigned PPC_LANES_DEF = 8;

  // Bits needed to hold a count from 0 up to and including lanes.
  function automatic int unsigned cnt_width(input int unsigned lanes);
    return $clog2(lanes + 1);
  endfunction

endpackage

// File: rtl/ppc_operand_sel.sv
module ppc_operand_sel #(
  parameter int unsigned LANES = 8
) (
  input  logic [LANES-1:0] src,
  input  logic [LANES-1:0] mask,
  input  logic             mask_en,
  input  logic             src_ones,
  output logic [LANES-1:0] lane_en,
  output logic [LANES-1:0] contrib
);

  logic [LANES-1:0] src_eff;

  always_comb begin
    lane_en = mask_en ? mask : {LANES{1'b1}};
    src_eff = src_ones ? {LANES{1'b1}} : src;
    // a disabled lane never feeds the counts above it
    contrib = src_eff & lane_en;
  end

endmodule

// File: rtl/ppc_prefix_chain.sv
module ppc_prefix_chain #(
  parameter int unsigned LANES = 8,
  parameter int unsigned CNT_W = 4
) (
  input  logic [LANES-1:0]       contrib,
  output logic [LANES*CNT_W-1:0] counts
);

  logic [CNT_W-1:0] run [LANES+1];

  assign run[0] = '0;

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_step
      // exclusive: lane i sees the sum of lanes 0..i-1 only
      assign counts[i*CNT_W +: CNT_W] = run[i];
      assign run[i+1] = run[i] + CNT_W'(contrib[i]);
    end
  endgenerate

  // grand total is not part of the result vector
  logic [CNT_W-1:0] total_unused;
  assign total_unused = run[LANES];

endmodule

// File: rtl/ppc_lane_merge.sv
module ppc_lane_merge #(
  parameter int unsigned LANES = 8,
  parameter int unsigned CNT_W = 4
) (
  input  logic [LANES-1:0]       lane_en,
  input  logic [LANES*CNT_W-1:0] counts,
  input  logic [LANES*CNT_W-1:0] old_dst,
  output logic [LANES*CNT_W-1:0] merged
);

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign merged[i*CNT_W +: CNT_W] = lane_en[i] ? counts[i*CNT_W +: CNT_W]
                                                   : old_dst[i*CNT_W +: CNT_W];
    end
  endgenerate

endmodule

// File: rtl/ppc_out_reg.sv
module ppc_out_reg #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);

  logic load;

  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // payload needs no reset, qualified by out_valid
  always_ff @(posedge clk) begin
    if (load) begin
      out_data <= in_data;
    end
  end

endmodule

// File: rtl/prefix_popcount_unit.sv
module prefix_popcount_unit
  import ppc_pkg::*;
#(
  parameter int unsigned LANES = PPC_LANES_DEF,
  parameter int unsigned CNT_W = cnt_width(LANES)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [LANES-1:0]       src,
  input  logic                   mask_en,
  input  logic [LANES-1:0]       mask,
  input  logic                   src_ones,
  input  logic [LANES*CNT_W-1:0] old_dst,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [LANES*CNT_W-1:0] dst
);

  localparam int unsigned DW = LANES * CNT_W;

  logic [LANES-1:0] lane_en;
  logic [LANES-1:0] contrib;
  logic [DW-1:0]    counts;
  logic [DW-1:0]    merged;

  ppc_operand_sel #(.LANES(LANES)) u_sel (
    .src      (src),
    .mask     (mask),
    .mask_en  (mask_en),
    .src_ones (src_ones),
    .lane_en  (lane_en),
    .contrib  (contrib)
  );

  ppc_prefix_chain #(.LANES(LANES), .CNT_W(CNT_W)) u_chain (
    .contrib (contrib),
    .counts  (counts)
  );

  ppc_lane_merge #(.LANES(LANES), .CNT_W(CNT_W)) u_merge (
    .lane_en (lane_en),
    .counts  (counts),
    .old_dst (old_dst),
    .merged  (merged)
  );

  ppc_out_reg #(.DW(DW)) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (merged),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (dst)
  );

endmodule

// File: rtl/ppc_checker.sv
module ppc_checker #(
  parameter int unsigned LANES = 8,
  parameter int unsigned CNT_W = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   mask_en,
  input logic [LANES-1:0]       mask,
  input logic                   src_ones,
  input logic [LANES*CNT_W-1:0] old_dst,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [LANES*CNT_W-1:0] dst
);

  logic take;
  assign take = in_valid && in_ready;

  assert_reset_idle_R9: assert property (@(posedge clk) rst |=> !out_valid);

  assert_accept_valid_R7: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid);

  assert_ready_when_empty_R7: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  assert_hold_stall_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(dst));

  assert_lane0_zero_R6: assert property (@(posedge clk) disable iff (rst)
    take && (!mask_en || mask[0]) |=> dst[CNT_W-1:0] == '0);

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
      assert_keep_old_R4: assert property (@(posedge clk) disable iff (rst)
        take && mask_en && !mask[i] |=>
          dst[i*CNT_W +: CNT_W] == $past(old_dst[i*CNT_W +: CNT_W]));

      assert_index_seq_R5: assert property (@(posedge clk) disable iff (rst)
        take && src_ones && !mask_en |=> dst[i*CNT_W +: CNT_W] == CNT_W'(i));
    end
  endgenerate

endmodule

bind prefix_popcount_unit ppc_checker #(.LANES(LANES), .CNT_W(CNT_W)) u_ppc_checker (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .mask_en   (mask_en),
  .mask      (mask),
  .src_ones  (src_ones),
  .old_dst   (old_dst),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .dst       (dst)
);

// File: tb/test_prefix_popcount_unit.sv
module test_prefix_popcount_unit;

  localparam int LANES = 8;
  localparam int CNT_W = 4;
  localparam int DW    = LANES * CNT_W;

  typedef struct packed {
    logic          me;
    logic          so;
    logic [7:0]    m;
    logic [7:0]    s;
    logic [31:0]   old;
    logic [31:0]   exp;
    logic [7:0]    req;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 8'h00, 8'b10010001, 32'h00000000, 32'h22211110, 8'd1},  // R1
    '{1'b1, 1'b0, 8'b11101011, 8'b10010001, 32'h23456789, 32'h11151710, 8'd3}, // R3 R4
    '{1'b0, 1'b1, 8'h00, 8'h00, 32'hFFFFFFFF, 32'h76543210, 8'd5},  // R5
    '{1'b0, 1'b0, 8'h00, 8'hFF, 32'h99999999, 32'h76543210, 8'd2},  // R2 mask ignored
    '{1'b1, 1'b1, 8'b01010101, 8'h00, 32'hFFFFFFFF, 32'hF3F2F1F0, 8'd10}, // R10
    '{1'b1, 1'b0, 8'hFE, 8'hFF, 32'hAAAAAAAA, 32'h6543210A, 8'd6},  // R6 lane0 off
    '{1'b1, 1'b0, 8'h00, 8'hFF, 32'h12345678, 32'h12345678, 8'd4},  // R4 all off
    '{1'b0, 1'b0, 8'h3C, 8'h80, 32'h55555555, 32'h00000000, 8'd1},  // R1 top bit only
    '{1'b1, 1'b0, 8'hFE, 8'h01, 32'h00000009, 32'h00000009, 8'd3}   // R3 masked bit0
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [7:0]    src = '0;
  logic          mask_en = 1'b0;
  logic [7:0]    mask = '0;
  logic          src_ones = 1'b0;
  logic [DW-1:0] old_dst = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [DW-1:0] dst;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  prefix_popcount_unit #(.LANES(LANES), .CNT_W(CNT_W)) i_prefix_popcount_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .src(src), .mask_en(mask_en), .mask(mask), .src_ones(src_ones),
    .old_dst(old_dst), .out_valid(out_valid), .out_ready(out_ready), .dst(dst)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // independent lane-by-lane count from the requirements
  function automatic logic [31:0] model(input logic me, input logic so,
      input logic [7:0] m, input logic [7:0] s, input logic [31:0] old);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < LANES; i++) begin
      if (!me || m[i]) begin
        int c;
        c = 0;
        for (int j = 0; j < i; j++)
          if ((so || s[j]) && (!me || m[j])) c++;
        r[i*CNT_W +: CNT_W] = 4'(c);
      end else begin
        r[i*CNT_W +: CNT_W] = old[i*CNT_W +: CNT_W];
      end
    end
    return r;
  endfunction

  task automatic put(input logic me, input logic so, input logic [7:0] m,
                     input logic [7:0] s, input logic [31:0] old);
    mask_en = me; src_ones = so; mask = m; src = s; old_dst = old;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R9 reset clears out_valid", 32'(out_valid), 32'd0);
    check(in_ready == 1'b1, "R7 ready while empty", 32'(in_ready), 32'd1);
    rst = 1'b0;

    // table walk, one accept per vector
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      put(VECS[k].me, VECS[k].so, VECS[k].m, VECS[k].s, VECS[k].old);
      in_valid = 1'b1; out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid == 1'b1, $sformatf("R7 valid vector %0d", k),
            32'(out_valid), 32'd1);
      check(dst == VECS[k].exp, $sformatf("R%0d vector %0d", VECS[k].req, k),
            dst, VECS[k].exp);
    end

    // pattern sweep against the model: R1 R2 R3 R4 R10
    for (int k = 0; k < 24; k++) begin
      logic [7:0] s, m;
      logic [31:0] o, e;
      logic me, so;
      s  = 8'(k * 37 + 11) ^ 8'(k << 3);
      m  = 8'(k * 91 + 5);
      o  = 32'(k * 32'h1F2E3D4C + 32'h0BADF00D);
      me = k[0];
      so = (k % 5) == 4;
      e  = model(me, so, m, s, o);
      @(negedge clk);
      put(me, so, m, s, o);
      in_valid = 1'b1; out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check(dst == e, $sformatf("R1/R3/R4 sweep %0d", k), dst, e);
    end

    // backpressure: R7 R8
    @(negedge clk);
    out_ready = 1'b0;
    put(1'b0, 1'b0, 8'h00, 8'b10010001, 32'h0);
    in_valid = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b1, "R7 accepted while stalled", 32'(out_valid), 32'd1);
    check(in_ready == 1'b0, "R7 ready low when full and stalled", 32'(in_ready), 32'd0);
    put(1'b0, 1'b1, 8'h00, 8'h00, 32'h0);
    @(negedge clk);
    check(dst == 32'h22211110, "R8 dst held under stall", dst, 32'h22211110);
    @(negedge clk);
    check(dst == 32'h22211110 && out_valid, "R8 dst held second cycle", dst, 32'h22211110);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(dst == 32'h76543210, "R7 next result after release", dst, 32'h76543210);
    @(negedge clk);
    check(out_valid == 1'b0, "R7 valid drops when drained", 32'(out_valid), 32'd0);

    // reset while holding a result: R9
    out_ready = 1'b0;
    put(1'b0, 1'b0, 8'h00, 8'hFF, 32'h0);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R9 reset during stall", 32'(out_valid), 32'd0);
    rst = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule